// File: doc/BRIEF.md
# APB GPIO Pin Bank

This block is the register side of a general-purpose I/O unit. An APB slave holds a data register and a direction register for each of up to four ports of up to 32 lines. From these it drives the pad output-enable and output-value buses. It returns the pad inputs through a read-only readback register per port, after a two-flop synchronizer. The synchronized port A value also goes to the interrupt detection logic, which lives outside this block.

Port A also carries interrupt control words and a debounce enable word. These are enable, mask, trigger type, polarity and debounce. The block presents them as plain outputs. It reads back an interrupt status vector supplied by the detection logic. A write to the end-of-interrupt location produces a one-cycle clear pulse. A build parameter moves the interrupt words to a second address layout. Each port's line count is a parameter, and bits above that count do not exist.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset every register is zero. All pad output enables and pad outputs are 0, every interrupt control output is 0, and reads of data and direction return 0.
- R2: Port p (p = 0..3) has its data word at byte offset 12*p and its direction word at 12*p+4. A write there is read back unchanged from the next transfer onwards.
- R3: pad_oe bit i equals direction bit i, where 1 means output. pad_out bit i equals data bit i when the line is an output and is 0 otherwise.
- R4: The pad readback for port p is at byte offset 0x50+4*p. A pad value present at clock edge k is visible on the readback and on pin_a_sync from edge k+2 onwards, and not at edge k+1.
- R5: With ALT_LAYOUT=0 the port A words sit at these offsets: interrupt enable 0x30, mask 0x34, trigger type 0x38, polarity 0x3C, status 0x40, debounce enable 0x48, end-of-interrupt 0x4C. Each writable word appears unchanged on its output.
- R6: With ALT_LAYOUT=1 the words move as follows: trigger type to 0x34, polarity to 0x38, status to 0x3C, end-of-interrupt to 0x40 and mask to 0x44. Enable (0x30) and debounce (0x48) keep their offsets, and 0x4C becomes unmapped.
- R7: The status word reads irq_status_in, limited to port A's line count. It is read-only: a write to it completes without error and changes nothing.
- R8: A write to end-of-interrupt sets eoi_pulse to the written value for exactly the one cycle after the write. A read of that word returns 0 without error.
- R9: An access to an unmapped, unaligned (paddr[1:0] != 0) or absent-port offset sets pslverr in the access phase and returns 0. A write there changes no register.
- R10: Bits at or above a port's configured line count read as 0 in data, direction and readback words, and are never driven on pad_oe or pad_out.
- R11: pready is always 1, so every transfer completes in its first access cycle. pslverr is 0 for every mapped offset and is only ever set during an access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero outside read access |
| pready | output | 1 | Transfer ready, always 1 |
| pslverr | output | 1 | Error response for unmapped offsets |
| pad_in | input | NUM_PORTS*32 | Raw pad inputs, port p in bits [32p+31:32p] |
| pad_out | output | NUM_PORTS*32 | Pad output values |
| pad_oe | output | NUM_PORTS*32 | Pad output enables |
| pin_a_sync | output | 32 | Synchronized port A inputs for interrupt logic |
| irq_status_in | input | 32 | Interrupt status from detection logic |
| irq_en | output | 32 | Interrupt enable word |
| irq_mask | output | 32 | Interrupt mask word |
| irq_type | output | 32 | Trigger type word |
| irq_pol | output | 32 | Trigger polarity word |
| deb_en | output | 32 | Debounce enable word |
| eoi_pulse | output | 32 | One-cycle end-of-interrupt clear bits |

## Verification
Two functions can act on the same line in the same cycle: a bus write to port A's data word, and a change of the raw pad input that the synchronizer is about to capture. The bench changes pad_in during the access phase of a data write. One cycle later it checks that pad_out already shows the new data while pin_a_sync still holds the old pad value. One more cycle later it checks that the readback shows the new pad value and not the written data.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned WORD_W     = 32;
   localparam int unsigned MAX_PORTS  = 4;
   localparam int unsigned CNT_W      = 8;
   localparam int unsigned SYNC_DEPTH = 2;

   typedef enum logic [3:0] {
      RS_NONE,
      RS_DATA,
      RS_DIR,
      RS_PIN,
      RS_IEN,
      RS_IMASK,
      RS_ITYPE,
      RS_IPOL,
      RS_ISTAT,
      RS_DEB,
      RS_EOI
   } reg_sel_e;

   typedef struct packed {
      reg_sel_e   sel;
      logic [1:0] port;
   } reg_hit_t;

   function automatic logic [WORD_W-1:0] line_mask(input int unsigned n);
      logic [WORD_W-1:0] m;
      for (int i = 0; i < WORD_W; i++) m[i] = (i < n);
      return m;
   endfunction

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PORTS  = 4,
   parameter int unsigned ADDR_W     = 8,
   parameter bit          ALT_LAYOUT = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_hit_t          hit
);

   localparam logic [6:0] OFF_IEN   = 7'h30;
   localparam logic [6:0] OFF_IMASK = ALT_LAYOUT ? 7'h44 : 7'h34;
   localparam logic [6:0] OFF_ITYPE = ALT_LAYOUT ? 7'h34 : 7'h38;
   localparam logic [6:0] OFF_IPOL  = ALT_LAYOUT ? 7'h38 : 7'h3C;
   localparam logic [6:0] OFF_ISTAT = ALT_LAYOUT ? 7'h3C : 7'h40;
   localparam logic [6:0] OFF_EOI   = ALT_LAYOUT ? 7'h40 : 7'h4C;
   localparam logic [6:0] OFF_DEB   = 7'h48;
   localparam int unsigned PORT_STRIDE = 12;
   localparam int unsigned PIN_BASE    = 80;
   localparam int unsigned PIN_STRIDE  = 4;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("gpio_bank_decode: ADDR_W must be at least 8");
   end

   logic [6:0] off;
   logic       in_window;

   assign off       = addr[6:0];
   assign in_window = (addr[ADDR_W-1:7] == '0) && (addr[1:0] == 2'b00);

   always_comb begin
      hit.sel  = RS_NONE;
      hit.port = 2'd0;
      if (in_window) begin
         for (int p = 0; p < MAX_PORTS; p++) begin
            if (p < int'(NUM_PORTS)) begin
               if (off == 7'(p * PORT_STRIDE)) begin
                  hit.sel  = RS_DATA;
                  hit.port = 2'(p);
               end
               if (off == 7'(p * PORT_STRIDE + 4)) begin
                  hit.sel  = RS_DIR;
                  hit.port = 2'(p);
               end
               if (off == 7'(PIN_BASE + p * PIN_STRIDE)) begin
                  hit.sel  = RS_PIN;
                  hit.port = 2'(p);
               end
            end
         end
         if (off == OFF_IEN)   hit.sel = RS_IEN;
         if (off == OFF_IMASK) hit.sel = RS_IMASK;
         if (off == OFF_ITYPE) hit.sel = RS_ITYPE;
         if (off == OFF_IPOL)  hit.sel = RS_IPOL;
         if (off == OFF_ISTAT) hit.sel = RS_ISTAT;
         if (off == OFF_DEB)   hit.sel = RS_DEB;
         if (off == OFF_EOI)   hit.sel = RS_EOI;
      end
   end

endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
   import gpio_bank_pkg::*;
#(
   parameter int unsigned LINES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_data,
   input  logic              wr_dir,
   input  logic [WORD_W-1:0] wdata,
   input  logic [WORD_W-1:0] pad_in,
   output logic [WORD_W-1:0] data_q,
   output logic [WORD_W-1:0] dir_q,
   output logic [WORD_W-1:0] pin_q,
   output logic [WORD_W-1:0] pad_out,
   output logic [WORD_W-1:0] pad_oe
);

   localparam logic [WORD_W-1:0] MASK = line_mask(LINES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
      end else begin
         if (wr_data) data_q <= wdata & MASK;
         if (wr_dir)  dir_q  <= wdata & MASK;
      end
   end

   logic [WORD_W-1:0] sync_q [SYNC_DEPTH];

   for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= '0;
            else        sync_q[s] <= pad_in & MASK;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= '0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   assign pin_q   = sync_q[SYNC_DEPTH-1];
   assign pad_oe  = dir_q;
   assign pad_out = data_q & dir_q;

   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             age_q <= 2'd0;
      else if (age_q != 2'd2) age_q <= age_q + 2'd1;
   end

   assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> (dir_q == ($past(wdata) & MASK)));

   assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd2) |-> (pin_q == ($past(pad_in, 2) & MASK)));

endmodule

// File: rtl/gpio_bank_irqregs.sv
module gpio_bank_irqregs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned LINES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ien,
   input  logic              wr_imask,
   input  logic              wr_itype,
   input  logic              wr_ipol,
   input  logic              wr_deb,
   input  logic              wr_eoi,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] ien,
   output logic [WORD_W-1:0] imask,
   output logic [WORD_W-1:0] itype,
   output logic [WORD_W-1:0] ipol,
   output logic [WORD_W-1:0] deb,
   output logic [WORD_W-1:0] eoi_pulse
);

   localparam int unsigned       NREG = 5;
   localparam logic [WORD_W-1:0] MASK = line_mask(LINES);

   logic [NREG-1:0]   wr_vec;
   logic [WORD_W-1:0] regs_q [NREG];

   assign wr_vec = {wr_deb, wr_ipol, wr_itype, wr_imask, wr_ien};

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         regs_q[r] <= '0;
         else if (wr_vec[r]) regs_q[r] <= wdata & MASK;
      end
   end

   assign ien   = regs_q[0];
   assign imask = regs_q[1];
   assign itype = regs_q[2];
   assign ipol  = regs_q[3];
   assign deb   = regs_q[4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      eoi_pulse <= '0;
      else if (wr_eoi) eoi_pulse <= wdata & MASK;
      else             eoi_pulse <= '0;
   end

   assert_eoi_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_pulse != '0) |-> $past(wr_eoi));

   assert_ien_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ien |=> $stable(ien));

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned                 NUM_PORTS  = 4,
   parameter int unsigned                 ADDR_W     = 8,
   parameter logic [MAX_PORTS*CNT_W-1:0]  PORT_LINES = {4{8'd32}},
   parameter bit                          ALT_LAYOUT = 1'b0
) (
   input  logic                        pclk,
   input  logic                        presetn,
   input  logic                        psel,
   input  logic                        penable,
   input  logic                        pwrite,
   input  logic [ADDR_W-1:0]           paddr,
   input  logic [WORD_W-1:0]           pwdata,
   output logic [WORD_W-1:0]           prdata,
   output logic                        pready,
   output logic                        pslverr,
   input  logic [NUM_PORTS*WORD_W-1:0] pad_in,
   output logic [NUM_PORTS*WORD_W-1:0] pad_out,
   output logic [NUM_PORTS*WORD_W-1:0] pad_oe,
   output logic [WORD_W-1:0]           pin_a_sync,
   input  logic [WORD_W-1:0]           irq_status_in,
   output logic [WORD_W-1:0]           irq_en,
   output logic [WORD_W-1:0]           irq_mask,
   output logic [WORD_W-1:0]           irq_type,
   output logic [WORD_W-1:0]           irq_pol,
   output logic [WORD_W-1:0]           deb_en,
   output logic [WORD_W-1:0]           eoi_pulse
);

   localparam int unsigned       LINES_A = PORT_LINES[CNT_W-1:0];
   localparam logic [WORD_W-1:0] MASK_A  = line_mask(LINES_A);

   if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
      $error("gpio_pin_bank: NUM_PORTS must be 1 to 4");
   end

   reg_hit_t hit;
   logic     access, wr_acc, rd_acc;

   assign access = psel & penable;
   assign wr_acc = access & pwrite;
   assign rd_acc = access & ~pwrite;

   gpio_bank_decode #(
      .NUM_PORTS (NUM_PORTS),
      .ADDR_W    (ADDR_W),
      .ALT_LAYOUT(ALT_LAYOUT)
   ) u_decode (
      .addr(paddr),
      .hit (hit)
   );

   logic [WORD_W-1:0] data_arr [MAX_PORTS];
   logic [WORD_W-1:0] dir_arr  [MAX_PORTS];
   logic [WORD_W-1:0] pin_arr  [MAX_PORTS];

   for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
      if (p < NUM_PORTS) begin : g_live
         localparam int unsigned LINES = PORT_LINES[p*CNT_W +: CNT_W];
         if (LINES == 0 || LINES > WORD_W) begin : g_bad_lines
            $error("gpio_pin_bank: port line count must be 1 to 32");
         end
         logic wr_d, wr_r;
         assign wr_d = wr_acc && (hit.sel == RS_DATA) && (hit.port == 2'(p));
         assign wr_r = wr_acc && (hit.sel == RS_DIR)  && (hit.port == 2'(p));
         gpio_bank_port #(.LINES(LINES)) u_port (
            .clk    (pclk),
            .rst_n  (presetn),
            .wr_data(wr_d),
            .wr_dir (wr_r),
            .wdata  (pwdata),
            .pad_in (pad_in [p*WORD_W +: WORD_W]),
            .data_q (data_arr[p]),
            .dir_q  (dir_arr[p]),
            .pin_q  (pin_arr[p]),
            .pad_out(pad_out[p*WORD_W +: WORD_W]),
            .pad_oe (pad_oe [p*WORD_W +: WORD_W])
         );
      end else begin : g_absent
         assign data_arr[p] = '0;
         assign dir_arr[p]  = '0;
         assign pin_arr[p]  = '0;
      end
   end

   gpio_bank_irqregs #(.LINES(LINES_A)) u_irq (
      .clk      (pclk),
      .rst_n    (presetn),
      .wr_ien   (wr_acc && hit.sel == RS_IEN),
      .wr_imask (wr_acc && hit.sel == RS_IMASK),
      .wr_itype (wr_acc && hit.sel == RS_ITYPE),
      .wr_ipol  (wr_acc && hit.sel == RS_IPOL),
      .wr_deb   (wr_acc && hit.sel == RS_DEB),
      .wr_eoi   (wr_acc && hit.sel == RS_EOI),
      .wdata    (pwdata),
      .ien      (irq_en),
      .imask    (irq_mask),
      .itype    (irq_type),
      .ipol     (irq_pol),
      .deb      (deb_en),
      .eoi_pulse(eoi_pulse)
   );

   logic [WORD_W-1:0] rd_word;

   always_comb begin
      case (hit.sel)
         RS_DATA:  rd_word = data_arr[hit.port];
         RS_DIR:   rd_word = dir_arr[hit.port];
         RS_PIN:   rd_word = pin_arr[hit.port];
         RS_IEN:   rd_word = irq_en;
         RS_IMASK: rd_word = irq_mask;
         RS_ITYPE: rd_word = irq_type;
         RS_IPOL:  rd_word = irq_pol;
         RS_ISTAT: rd_word = irq_status_in & MASK_A;
         RS_DEB:   rd_word = deb_en;
         default:  rd_word = '0;
      endcase
   end

   assign prdata     = rd_acc ? rd_word : '0;
   assign pslverr    = access && (hit.sel == RS_NONE);
   assign pready     = 1'b1;
   assign pin_a_sync = pin_arr[0];

   assert_err_zero_R9: assert property (@(posedge pclk) disable iff (!presetn)
      pslverr |-> (prdata == '0));

   assert_err_access_R11: assert property (@(posedge pclk) disable iff (!presetn)
      pslverr |-> (psel && penable));

endmodule

// File: tb/tb_gpio_pin_bank.sv
module tb_gpio_pin_bank;
   import gpio_bank_pkg::*;

   localparam int unsigned NP = 3;
   localparam logic [31:0] LINES_CFG = {8'd32, 8'd8, 8'd16, 8'd32};

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic        psel_m, psel_a, penable, pwrite;
   logic [7:0]  paddr;
   logic [31:0] pwdata;

   logic [31:0]      prdata_m, prdata_a;
   logic             pready_m, pready_a, err_m, err_a;
   logic [NP*32-1:0] pad_in_m, pad_out_m, pad_oe_m;
   logic [127:0]     pad_in_a, pad_out_a, pad_oe_a;
   logic [31:0]      sync_m, sync_a, stat_m, stat_a;
   logic [31:0]      ien_m, imask_m, itype_m, ipol_m, deb_m, eoi_m;
   logic [31:0]      ien_a, imask_a, itype_a, ipol_a, deb_a, eoi_a;

   gpio_pin_bank #(.NUM_PORTS(NP), .ADDR_W(8), .PORT_LINES(LINES_CFG), .ALT_LAYOUT(1'b0)) dut (
      .pclk(clk), .presetn(rst_n), .psel(psel_m), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata_m), .pready(pready_m), .pslverr(err_m),
      .pad_in(pad_in_m), .pad_out(pad_out_m), .pad_oe(pad_oe_m), .pin_a_sync(sync_m),
      .irq_status_in(stat_m), .irq_en(ien_m), .irq_mask(imask_m), .irq_type(itype_m),
      .irq_pol(ipol_m), .deb_en(deb_m), .eoi_pulse(eoi_m));

   gpio_pin_bank #(.NUM_PORTS(4), .ADDR_W(8), .PORT_LINES({4{8'd32}}), .ALT_LAYOUT(1'b1)) dut_alt (
      .pclk(clk), .presetn(rst_n), .psel(psel_a), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a), .pready(pready_a), .pslverr(err_a),
      .pad_in(pad_in_a), .pad_out(pad_out_a), .pad_oe(pad_oe_a), .pin_a_sync(sync_a),
      .irq_status_in(stat_a), .irq_en(ien_a), .irq_mask(imask_a), .irq_type(itype_a),
      .irq_pol(ipol_a), .deb_en(deb_a), .eoi_pulse(eoi_a));

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apb(input bit alt, input bit wr, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic err, output logic rdy);
      @(negedge clk);
      psel_m = !alt; psel_a = alt; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      #1;
      rd  = alt ? prdata_a : prdata_m;
      err = alt ? err_a : err_m;
      rdy = alt ? pready_a : pready_m;
      @(negedge clk);
      psel_m = 1'b0; psel_a = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic        err;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 31;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h00, 32'hA5A55A5A, 32'h0,        1'b0, 4'd2},
      '{1'b0, 8'h00, 32'h0,        32'hA5A55A5A, 1'b0, 4'd2},
      '{1'b1, 8'h0C, 32'hFFFFFFFF, 32'h0,        1'b0, 4'd10},
      '{1'b0, 8'h0C, 32'h0,        32'h0000FFFF, 1'b0, 4'd10},
      '{1'b1, 8'h1C, 32'h12345678, 32'h0,        1'b0, 4'd10},
      '{1'b0, 8'h1C, 32'h0,        32'h00000078, 1'b0, 4'd10},
      '{1'b1, 8'h04, 32'hFFFF0000, 32'h0,        1'b0, 4'd2},
      '{1'b0, 8'h04, 32'h0,        32'hFFFF0000, 1'b0, 4'd2},
      '{1'b1, 8'h30, 32'h000000F0, 32'h0,        1'b0, 4'd5},
      '{1'b0, 8'h30, 32'h0,        32'h000000F0, 1'b0, 4'd5},
      '{1'b1, 8'h34, 32'h00000011, 32'h0,        1'b0, 4'd5},
      '{1'b0, 8'h34, 32'h0,        32'h00000011, 1'b0, 4'd5},
      '{1'b1, 8'h38, 32'h00000022, 32'h0,        1'b0, 4'd5},
      '{1'b0, 8'h38, 32'h0,        32'h00000022, 1'b0, 4'd5},
      '{1'b1, 8'h3C, 32'h00000033, 32'h0,        1'b0, 4'd5},
      '{1'b0, 8'h3C, 32'h0,        32'h00000033, 1'b0, 4'd5},
      '{1'b1, 8'h48, 32'h00000044, 32'h0,        1'b0, 4'd5},
      '{1'b0, 8'h48, 32'h0,        32'h00000044, 1'b0, 4'd5},
      '{1'b0, 8'h4C, 32'h0,        32'h0,        1'b0, 4'd8},
      '{1'b0, 8'h24, 32'h0,        32'h0,        1'b1, 4'd9},
      '{1'b1, 8'h28, 32'hFFFFFFFF, 32'h0,        1'b1, 4'd9},
      '{1'b0, 8'h08, 32'h0,        32'h0,        1'b1, 4'd9},
      '{1'b0, 8'h44, 32'h0,        32'h0,        1'b1, 4'd9},
      '{1'b0, 8'h01, 32'h0,        32'h0,        1'b1, 4'd9},
      '{1'b0, 8'h5C, 32'h0,        32'h0,        1'b1, 4'd9},
      '{1'b0, 8'h80, 32'h0,        32'h0,        1'b1, 4'd9},
      '{1'b1, 8'h10, 32'h0000FFFF, 32'h0,        1'b0, 4'd2},
      '{1'b0, 8'h10, 32'h0,        32'h0000FFFF, 1'b0, 4'd2},
      '{1'b1, 8'h08, 32'hFFFFFFFF, 32'h0,        1'b1, 4'd9},
      '{1'b1, 8'h01, 32'h00000000, 32'h0,        1'b1, 4'd9},
      '{1'b0, 8'h00, 32'h0,        32'hA5A55A5A, 1'b0, 4'd9}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic        er, rdy;
      string       rq;

      rst_n = 1'b0; psel_m = 1'b0; psel_a = 1'b0; penable = 1'b0; pwrite = 1'b0;
      paddr = '0; pwdata = '0; pad_in_m = '0; pad_in_a = '0; stat_m = '0; stat_a = 32'h55;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1", "pad_oe A", pad_oe_m[31:0], 32'h0);
      check("R1", "pad_out A", pad_out_m[31:0], 32'h0);
      check("R1", "irq_en", ien_m, 32'h0);
      check("R1", "deb_en", deb_m, 32'h0);
      check("R1", "eoi", eoi_m, 32'h0);
      apb(1'b0, 1'b0, 8'h00, 32'h0, rd, er, rdy);
      check("R1", "data A read", rd, 32'h0);

      for (int i = 0; i < NV; i++) begin
         apb(1'b0, VEC[i].wr, VEC[i].addr, VEC[i].data, rd, er, rdy);
         rq = $sformatf("R%0d", VEC[i].req);
         check(rq, $sformatf("prdata @%h", VEC[i].addr), rd, VEC[i].exp);
         check(rq, $sformatf("pslverr @%h", VEC[i].addr), {31'b0, er}, {31'b0, VEC[i].err});
         check("R11", "pready", {31'b0, rdy}, 32'h1);
      end

      // R3 / R10: pad drive from data and direction
      check("R3", "pad_out A", pad_out_m[31:0], 32'hA5A50000);
      check("R3", "pad_oe A", pad_oe_m[31:0], 32'hFFFF0000);
      check("R3", "pad_out B", pad_out_m[63:32], 32'h0000FFFF);
      check("R3", "pad_out C", pad_out_m[95:64], 32'h0);
      check("R10", "pad_oe C", pad_oe_m[95:64], 32'h00000078);
      // R5: control outputs
      check("R5", "irq_en", ien_m, 32'hF0);
      check("R5", "irq_mask", imask_m, 32'h11);
      check("R5", "irq_type", itype_m, 32'h22);
      check("R5", "irq_pol", ipol_m, 32'h33);
      check("R5", "deb_en", deb_m, 32'h44);

      // R4: two-edge synchronizer latency
      pad_in_m = {32'h000001FF, 32'hFFFFFFFF, 32'hDEADBEEF};
      @(negedge clk);
      check("R4", "sync after one edge", sync_m, 32'h0);
      @(negedge clk);
      check("R4", "sync after two edges", sync_m, 32'hDEADBEEF);
      apb(1'b0, 1'b0, 8'h50, 32'h0, rd, er, rdy);
      check("R4", "pin A read", rd, 32'hDEADBEEF);
      apb(1'b0, 1'b0, 8'h54, 32'h0, rd, er, rdy);
      check("R10", "pin B read", rd, 32'h0000FFFF);
      apb(1'b0, 1'b0, 8'h58, 32'h0, rd, er, rdy);
      check("R10", "pin C read", rd, 32'h000000FF);

      // R7: status read-only
      stat_m = 32'hCAFE0001;
      apb(1'b0, 1'b0, 8'h40, 32'h0, rd, er, rdy);
      check("R7", "status read", rd, 32'hCAFE0001);
      apb(1'b0, 1'b1, 8'h40, 32'h0, rd, er, rdy);
      check("R7", "status write err", {31'b0, er}, 32'h0);
      apb(1'b0, 1'b0, 8'h40, 32'h0, rd, er, rdy);
      check("R7", "status after write", rd, 32'hCAFE0001);

      // R8: end-of-interrupt pulse
      apb(1'b0, 1'b1, 8'h4C, 32'h00000081, rd, er, rdy);
      check("R8", "eoi pulse", eoi_m, 32'h81);
      @(negedge clk);
      check("R8", "eoi cleared", eoi_m, 32'h0);
      check("R8", "irq_en untouched", ien_m, 32'hF0);

      // Same cycle: data write while port A pad changes
      @(negedge clk);
      psel_m = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'hFFFFFFFF;
      @(negedge clk);
      penable = 1'b1;
      pad_in_m[31:0] = 32'h12345678;
      @(negedge clk);
      psel_m = 1'b0; penable = 1'b0; pwrite = 1'b0;
      check("R3", "pad_out after write", pad_out_m[31:0], 32'hFFFF0000);
      check("R4", "sync still old", sync_m, 32'hDEADBEEF);
      @(negedge clk);
      check("R4", "sync new", sync_m, 32'h12345678);
      apb(1'b0, 1'b0, 8'h50, 32'h0, rd, er, rdy);
      check("R4", "pin A shows pad", rd, 32'h12345678);

      // R6: alternate layout
      apb(1'b1, 1'b1, 8'h34, 32'hA1, rd, er, rdy);
      apb(1'b1, 1'b1, 8'h38, 32'hB2, rd, er, rdy);
      apb(1'b1, 1'b1, 8'h44, 32'hC3, rd, er, rdy);
      check("R6", "mask write err", {31'b0, er}, 32'h0);
      apb(1'b1, 1'b1, 8'h30, 32'h05, rd, er, rdy);
      check("R6", "alt type", itype_a, 32'hA1);
      check("R6", "alt pol", ipol_a, 32'hB2);
      check("R6", "alt mask", imask_a, 32'hC3);
      check("R6", "alt en", ien_a, 32'h05);
      apb(1'b1, 1'b0, 8'h3C, 32'h0, rd, er, rdy);
      check("R6", "alt status", rd, 32'h55);
      apb(1'b1, 1'b0, 8'h40, 32'h0, rd, er, rdy);
      check("R6", "alt eoi read err", {31'b0, er}, 32'h0);
      apb(1'b1, 1'b1, 8'h40, 32'h3, rd, er, rdy);
      check("R6", "alt eoi pulse", eoi_a, 32'h3);
      apb(1'b1, 1'b0, 8'h4C, 32'h0, rd, er, rdy);
      check("R6", "alt 0x4C unmapped", {31'b0, er}, 32'h1);
      apb(1'b1, 1'b1, 8'h24, 32'hBEEF, rd, er, rdy);
      apb(1'b1, 1'b0, 8'h24, 32'h0, rd, er, rdy);
      check("R2", "alt port D data", rd, 32'hBEEF);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule